// File: doc/BRIEF.md
# Multi-Cluster CPU Reset Controller

This block holds the reset lines of a set of CPU clusters. Each cluster has per-core core, NEON and core-debug resets, plus a cluster L2 reset and a cluster debug reset. Software controls the lines through a small register bus, using one register pair per cluster. A write of ones to the set register puts the selected lines into reset. A write of ones to the clear register takes the selected lines out of reset. A read-only status word per cluster shows which lines are still held. It also shows the synchronized wait-for-interrupt, wait-for-event and debug-acknowledge signals of each core.

A line leaves reset on the cycle after its release write. Its status bit stays at one for a settle time set by the `settle_i` input, so a boot routine can poll the status word for completion. A core cannot leave reset while the debug reset of its cluster is still held. The write and read paths have no wait states. Read data is combinational from the address.

Top module: `cpu_cluster_rst_ctrl`

## Requirements
- R1: For cluster k, the set register is at byte offset 0x520+8k, the clear register is at 0x524+8k and the status word is at 0x1520+8k.
- R2: In the set and clear registers and in the low status bits, core c uses bit c for its core reset, bit 4+c for NEON and bit 9+c for core debug. Bit 8 is the cluster L2 reset and bit 13 is the cluster debug reset.
- R3: Ones written to a set or clear register act only on the selected lines. Zero bits, and bits outside the layout of R2, change nothing.
- R4: A status bit of a control line reads 1 while the line is held. A set write shows in status on the next cycle. After a clear write, the reset output drops on the next cycle, but the status bit stays 1 for settle_i+1 cycles.
- R5: A clear of a core reset bit has no effect while the cluster debug reset is held at the time of the write. This holds even when the same write also clears the cluster debug reset.
- R6: After rst_ni all lines are held, except cluster 0's core 0 lines (core, NEON, core debug), its L2 reset and its cluster debug reset.
- R7: Reads of any address other than a status word return 0. This includes the set and clear registers. Writes to unmapped addresses and to status words change nothing.
- R8: Status bits 16+c, 20+c and 24+c show core c's WFI, WFE and debug-acknowledge inputs two clock cycles after they change.
- R9: If a set write lands in the same cycle in which a line's settle count expires, the line ends up held, and its status reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| settle_i | input | SETTLE_W | Extra status-hold cycles after a release |
| addr_i | input | ADDR_W | Byte address |
| we_i | input | 1 | Write enable |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i |
| wfi_i | input | NCL*NCO | Per-core WFI, index k*NCO+c |
| wfe_i | input | NCL*NCO | Per-core WFE |
| dbg_ack_i | input | NCL*NCO | Per-core debug acknowledge |
| core_rst_o | output | NCL*NCO | Core resets, 1 = held |
| neon_rst_o | output | NCL*NCO | NEON resets, 1 = held |
| core_dbg_rst_o | output | NCL*NCO | Core debug resets, 1 = held |
| l2_rst_o | output | NCL | Cluster L2 resets, 1 = held |
| cl_dbg_rst_o | output | NCL | Cluster debug resets, 1 = held |

## Verification
Two events can fall on the same edge: the expiry of a settle count and a new set write to the same cluster. The bench releases the L2 and debug resets of one cluster with a settle value of 3. It then times a set write of the debug reset so that it lands exactly on the expiry edge. The L2 bit must clear on that edge while the debug bit stays held. A second overlap is a single write that clears both the cluster debug reset and a core. The core must stay held, because the ordering check uses the state from before the write.

// File: rtl/cpu_rst_pkg.sv
package cpu_rst_pkg;
  localparam int CORE_LSB  = 0;
  localparam int NEON_LSB  = 4;
  localparam int L2_BIT    = 8;
  localparam int CDBG_LSB  = 9;
  localparam int CL_DBG_BIT = 13;
  localparam int LINE_W    = 14;
  localparam int WFI_LSB   = 16;
  localparam int WFE_LSB   = 20;
  localparam int ACK_LSB   = 24;
  localparam int MAX_CORES = 4;

  function automatic logic [LINE_W-1:0] line_mask(int nco);
    logic [LINE_W-1:0] m;
    m = '0;
    for (int c = 0; c < nco; c++) begin
      m[CORE_LSB+c] = 1'b1;
      m[NEON_LSB+c] = 1'b1;
      m[CDBG_LSB+c] = 1'b1;
    end
    m[L2_BIT]     = 1'b1;
    m[CL_DBG_BIT] = 1'b1;
    return m;
  endfunction

  function automatic logic [LINE_W-1:0] boot_released();
    logic [LINE_W-1:0] m;
    m = '0;
    m[CORE_LSB]   = 1'b1;
    m[NEON_LSB]   = 1'b1;
    m[CDBG_LSB]   = 1'b1;
    m[L2_BIT]     = 1'b1;
    m[CL_DBG_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/cpu_rst_sync.sv
module cpu_rst_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/cpu_rst_cluster.sv
module cpu_rst_cluster
  import cpu_rst_pkg::*;
#(
  parameter int NCO      = 4,
  parameter int SETTLE_W = 8,
  parameter bit BOOT     = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                set_i,
  input  logic                clr_i,
  input  logic [LINE_W-1:0]   wmask_i,
  input  logic [SETTLE_W-1:0] settle_i,
  output logic [LINE_W-1:0]   rst_o,
  output logic [LINE_W-1:0]   stat_o
);
  localparam logic [LINE_W-1:0] MASK = line_mask(NCO);
  localparam logic [LINE_W-1:0] INIT = BOOT ? (MASK & ~boot_released()) : MASK;

  logic [LINE_W-1:0]   rst_q, rst_d, pend_q, pend_d, set_m, clr_m, rel_m;
  logic [SETTLE_W-1:0] cnt_q, cnt_d;

  always_comb begin
    set_m = set_i ? (wmask_i & MASK) : '0;
    clr_m = clr_i ? (wmask_i & MASK) : '0;
    // cores stay held until cluster debug reset is already out
    if (rst_q[CL_DBG_BIT]) clr_m[CORE_LSB +: NCO] = '0;
    rel_m = clr_m & rst_q;
    rst_d = (rst_q | set_m) & ~clr_m;

    pend_d = pend_q;
    cnt_d  = cnt_q;
    if (|rel_m) begin
      pend_d = pend_q | rel_m;
      cnt_d  = settle_i;
    end else if (|pend_q) begin
      if (cnt_q == '0) pend_d = '0;
      else             cnt_d  = cnt_q - SETTLE_W'(1);
    end
    pend_d = pend_d & ~set_m;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q  <= INIT;
      pend_q <= '0;
      cnt_q  <= '0;
    end else begin
      rst_q  <= rst_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  assign rst_o  = rst_q;
  assign stat_o = rst_q | pend_q;

  // R5
  core_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q[CL_DBG_BIT] |=> ((rst_q[CORE_LSB +: NCO] & $past(rst_q[CORE_LSB +: NCO]))
                           == $past(rst_q[CORE_LSB +: NCO])));
  // R3
  set_sticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((rst_q & $past(wmask_i & MASK)) == $past(wmask_i & MASK)));
  // R3
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(rst_q));
  // R4
  settle_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|pend_q) && !clr_i && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - SETTLE_W'(1)));
endmodule

// File: rtl/cpu_cluster_rst_ctrl.sv
module cpu_cluster_rst_ctrl
  import cpu_rst_pkg::*;
#(
  parameter int NCL       = 4,
  parameter int NCO       = 4,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int SETTLE_W  = 8,
  parameter int SET_BASE  = 'h520,
  parameter int CLR_BASE  = 'h524,
  parameter int STAT_BASE = 'h1520,
  parameter int STRIDE    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NCL*NCO-1:0]  wfi_i,
  input  logic [NCL*NCO-1:0]  wfe_i,
  input  logic [NCL*NCO-1:0]  dbg_ack_i,
  output logic [NCL*NCO-1:0]  core_rst_o,
  output logic [NCL*NCO-1:0]  neon_rst_o,
  output logic [NCL*NCO-1:0]  core_dbg_rst_o,
  output logic [NCL-1:0]      l2_rst_o,
  output logic [NCL-1:0]      cl_dbg_rst_o
);
  localparam int NLN = NCL * NCO;

  logic [NLN-1:0]    wfi_s, wfe_s, ack_s;
  logic [NCL-1:0]    set_hit, clr_hit, stat_hit;
  logic [LINE_W-1:0] line_q [NCL];
  logic [LINE_W-1:0] stat_l [NCL];
  logic [DATA_W-1:0] stat_w [NCL];

  cpu_rst_sync #(.W(3*NLN)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({dbg_ack_i, wfe_i, wfi_i}),
    .q_o    ({ack_s, wfe_s, wfi_s})
  );

  for (genvar k = 0; k < NCL; k++) begin : g_cl
    assign set_hit[k]  = we_i && (addr_i == ADDR_W'(SET_BASE  + STRIDE*k));
    assign clr_hit[k]  = we_i && (addr_i == ADDR_W'(CLR_BASE  + STRIDE*k));
    assign stat_hit[k] = (addr_i == ADDR_W'(STAT_BASE + STRIDE*k));

    cpu_rst_cluster #(.NCO(NCO), .SETTLE_W(SETTLE_W), .BOOT(k == 0)) u_cl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (set_hit[k]),
      .clr_i    (clr_hit[k]),
      .wmask_i  (wdata_i[LINE_W-1:0]),
      .settle_i (settle_i),
      .rst_o    (line_q[k]),
      .stat_o   (stat_l[k])
    );

    always_comb begin
      stat_w[k] = '0;
      stat_w[k][LINE_W-1:0] = stat_l[k];
      for (int c = 0; c < NCO; c++) begin
        stat_w[k][WFI_LSB+c] = wfi_s[k*NCO+c];
        stat_w[k][WFE_LSB+c] = wfe_s[k*NCO+c];
        stat_w[k][ACK_LSB+c] = ack_s[k*NCO+c];
      end
    end

    assign core_rst_o[k*NCO +: NCO]     = line_q[k][CORE_LSB +: NCO];
    assign neon_rst_o[k*NCO +: NCO]     = line_q[k][NEON_LSB +: NCO];
    assign core_dbg_rst_o[k*NCO +: NCO] = line_q[k][CDBG_LSB +: NCO];
    assign l2_rst_o[k]     = line_q[k][L2_BIT];
    assign cl_dbg_rst_o[k] = line_q[k][CL_DBG_BIT];
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NCL; k++)
      if (stat_hit[k]) rdata_o = stat_w[k];
  end

  // R7
  unmapped_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_hit == '0) |-> (rdata_o == '0));
endmodule

// File: tb/cpu_cluster_rst_ctrl_test.sv
`timescale 1ns/1ps
module cpu_cluster_rst_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  settle_i = '0;
  logic [15:0] addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [15:0] wfi_i = '0, wfe_i = '0, dbg_ack_i = '0;
  logic [15:0] core_rst_o, neon_rst_o, core_dbg_rst_o;
  logic [3:0]  l2_rst_o, cl_dbg_rst_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  cpu_cluster_rst_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .settle_i(settle_i),
    .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .wfi_i(wfi_i), .wfe_i(wfe_i), .dbg_ack_i(dbg_ack_i),
    .core_rst_o(core_rst_o), .neon_rst_o(neon_rst_o),
    .core_dbg_rst_o(core_dbg_rst_o), .l2_rst_o(l2_rst_o),
    .cl_dbg_rst_o(cl_dbg_rst_o)
  );

  // {req 4, waddr 16, wdata 32, wait 4, raddr 16, expect 32}
  localparam int NV = 10;
  localparam logic [103:0] VEC [NV] = '{
    {4'd5, 16'h052C, 32'h0000_0001, 4'd2, 16'h1528, 32'h0000_3FFF}, // R5 core gated
    {4'd4, 16'h052C, 32'h0000_2000, 4'd0, 16'h1528, 32'h0000_3FFF}, // R4 still pending
    {4'd7, 16'h0000, 32'hFFFF_FFFF, 4'd0, 16'h1528, 32'h0000_1FFF}, // R7 R4 settle done
    {4'd2, 16'h052C, 32'h0000_0211, 4'd1, 16'h1528, 32'h0000_1DEE}, // R2 core0 lines
    {4'd1, 16'h0520, 32'h0000_0001, 4'd0, 16'h1520, 32'h0000_1CEF}, // R1 R4 set next cycle
    {4'd3, 16'h0524, 32'hFFFF_FFFF, 4'd1, 16'h1520, 32'h0000_0000}, // R3 all released
    {4'd3, 16'h0538, 32'h0000_2000, 4'd0, 16'h1538, 32'h0000_3FFF}, // R3 no change
    {4'd7, 16'h1000, 32'h0000_FFFF, 4'd0, 16'h0524, 32'h0000_0000}, // R7 control reads 0
    {4'd7, 16'h1520, 32'h0000_3FFF, 4'd0, 16'h1520, 32'h0000_0000}, // R7 status write ignored
    {4'd5, 16'h0534, 32'h0000_2002, 4'd1, 16'h1530, 32'h0000_1FFF}  // R5 same-write gating
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input string req, input logic [15:0] a, input logic [31:0] exp);
    addr_i = a;
    #1;
    chk(req, rdata_o, exp);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R6 power-on state
    chk("R6", {core_rst_o, neon_rst_o}, 32'hFFFE_FFFE);
    chk("R6", {16'h0, core_dbg_rst_o}, 32'h0000_FFFE);
    chk("R6", {24'h0, l2_rst_o, cl_dbg_rst_o}, 32'h0000_00EE);
    rd("R6", 16'h1520, 32'h0000_1CEE);
    rd("R6", 16'h1528, 32'h0000_3FFF);

    for (int i = 0; i < NV; i++) begin
      logic [103:0] v;
      v = VEC[i];
      wr(v[99:84], v[83:52]);
      repeat (int'(v[51:48])) @(negedge clk_i);
      rd($sformatf("R%0d vec%0d", v[103:100], i), v[47:32], v[31:0]);
    end

    // R7 reads beyond the map and off the stride
    rd("R7", 16'h1540, 32'h0);
    rd("R7", 16'h1524, 32'h0);

    // R4 settle delay: release cluster 2 L2 with settle 5
    settle_i = 8'd5;
    wr(16'h0534, 32'h0000_0100);
    chk("R4 output", {31'h0, l2_rst_o[2]}, 32'h0);
    repeat (5) @(negedge clk_i);
    rd("R4 hold", 16'h1530, 32'h0000_1FFF);
    @(negedge clk_i);
    rd("R4 clear", 16'h1530, 32'h0000_1EFF);

    // R9 set write on the settle-expiry edge
    settle_i = 8'd3;
    wr(16'h053C, 32'h0000_2100);
    repeat (2) @(negedge clk_i);
    wr(16'h0538, 32'h0000_2000);
    rd("R9", 16'h1538, 32'h0000_3EFF);
    chk("R9 output", {30'h0, cl_dbg_rst_o[3], l2_rst_o[3]}, 32'h2);

    // R8 two-stage sync of cluster 1 core 2
    @(negedge clk_i);
    wfi_i[6] = 1'b1; wfe_i[6] = 1'b1; dbg_ack_i[6] = 1'b1;
    @(negedge clk_i);
    rd("R8 one edge", 16'h1528, 32'h0000_1DEE);
    @(negedge clk_i);
    rd("R8 two edges", 16'h1528, 32'h0444_1DEE);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule